// File: doc/BRIEF.md
# Adaptive Pulse Neuron

This block is a single digital neuron built from two small saturating counters and an equality comparator. A synapse count integrates single-cycle excitatory and inhibitory pulses. A threshold count holds the level the synapse must reach before the neuron fires. When the two registered counts are equal, the neuron clears its synapse count, lowers its threshold by one and raises a one-cycle fire pulse. The effect is that a busy neuron fires more and more easily.

Two further pulse inputs set how fast the neuron forgets. A recovery pulse raises the threshold by one step, so a neuron that stays quiet slowly becomes harder to fire again. A leak pulse drains the synapse count by one step toward zero in cycles where no excitatory or inhibitory pulse arrives. All inputs are synchronous to the clock and are sampled on every edge. Each pulse is a plain level for one cycle, with no valid/ready handshake and no back-pressure: a pulse is never refused and never held for later.

Top module: `adaptive_neuron`

## Requirements
- R1: While `rst` is high at a clock edge, the synapse count goes to 0, the threshold to the parameter `INIT_THRESH` (default 31, clamped into 1..2^CNT_W-1) and `fire` to 0.
- R2: When not firing, an edge with `excite` high and `inhibit` low raises the synapse count by one, and an edge with `inhibit` high and `excite` low lowers it by one.
- R3: When `excite` and `inhibit` are both high at the same edge, the two cancel: the synapse count is unchanged and `leak` has no effect in that cycle.
- R4: The synapse count saturates: it stays at 0 on a lowering step and at 2^CNT_W-1 on a raising step.
- R5: When not firing, an edge with `leak` high and both `excite` and `inhibit` low lowers the synapse count by one, stopping at 0.
- R6: The comparison uses the registered counts. When they are equal at an edge, that edge clears the synapse count to 0 and `fire` is high for the following cycle.
- R7: Each firing lowers the threshold by one, but never below 1.
- R8: When not firing, an edge with `recover` high raises the threshold by one, stopping at 2^CNT_W-1.
- R9: A firing edge overrides everything else in that cycle: `excite`, `inhibit` and `leak` do not change the cleared synapse count, and `recover` does not cancel the threshold decrement.
- R10: `fire` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| excite | input | 1 | Excitatory pulse, one cycle per event |
| inhibit | input | 1 | Inhibitory pulse, one cycle per event |
| leak | input | 1 | Synapse decay rate pulse |
| recover | input | 1 | Threshold recovery rate pulse |
| fire | output | 1 | One-cycle output pulse of the neuron |
| syn_count | output | CNT_W | Present synapse count |
| threshold | output | CNT_W | Present firing threshold |

## Verification
Directed runs first drive only excitation, only inhibition, both together and only leak. Each of these moves the synapse count by a different rule, so a wrong priority between them shows up at once. A long excitation run then walks the threshold down to its floor of 1 and fires there repeatedly. This separates a threshold that clamps at 1 from one that wraps or stalls. Recovery bursts push the threshold against its ceiling, and cycles where an input pulse and `recover` coincide with firing show whether the fire update wins. A seeded random mix of all four pulses, at densities that make firing frequent, is checked cycle by cycle against a reference model in the bench.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic step_e syn_step(input logic up, input logic down, input logic drain);
    if (up && !down)       return STEP_UP;
    else if (down && !up)  return STEP_DOWN;
    else if (!up && !down && drain) return STEP_DOWN;
    else                   return STEP_HOLD;
  endfunction

endpackage

// File: rtl/neuron_syn_acc.sv
module neuron_syn_acc
  import neuron_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_now,
  input  logic             excite,
  input  logic             inhibit,
  input  logic             leak,
  output logic [CNT_W-1:0] level
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  step_e            step;
  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_d;

  always_comb begin
    step = syn_step(excite, inhibit, leak);
    level_d = level_q;
    if (fire_now) begin
      level_d = '0;
    end else begin
      unique case (step)
        STEP_UP:   if (level_q != CNT_MAX) level_d = level_q + 1'b1;
        STEP_DOWN: if (level_q != '0)      level_d = level_q - 1'b1;
        default:   level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  assign level = level_q;

  // R2
  syn_up_chk: assert property (@(posedge clk) disable iff (rst)
    (excite && !inhibit && !fire_now && level_q != CNT_MAX) |=> level_q == $past(level_q) + 1'b1);

  // R3
  syn_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (excite && inhibit && !fire_now) |=> $stable(level_q));

  // R5
  syn_leak_chk: assert property (@(posedge clk) disable iff (rst)
    (leak && !excite && !inhibit && !fire_now && level_q != '0) |=> level_q == $past(level_q) - 1'b1);

  // R9
  syn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire_now |=> level_q == '0);

endmodule

// File: rtl/neuron_wgt_acc.sv
module neuron_wgt_acc #(
  parameter int CNT_W = 5,
  parameter int INIT_THRESH = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_now,
  input  logic             recover,
  output logic [CNT_W-1:0] level
);
  localparam int CNT_MAX_I = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam int INIT_I = (INIT_THRESH < 1) ? 1 :
                          (INIT_THRESH > CNT_MAX_I) ? CNT_MAX_I : INIT_THRESH;
  localparam logic [CNT_W-1:0] INIT_VAL = CNT_W'(INIT_I);

  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_d;

  always_comb begin
    level_d = level_q;
    if (fire_now) begin
      if (level_q > CNT_MIN) level_d = level_q - 1'b1;
    end else if (recover) begin
      if (level_q != CNT_MAX) level_d = level_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= INIT_VAL;
    else     level_q <= level_d;
  end

  assign level = level_q;

  // R7
  wgt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    level_q != '0);

  // R8
  wgt_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (recover && !fire_now && level_q != CNT_MAX) |=> level_q == $past(level_q) + 1'b1);

  // R9
  wgt_fire_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (fire_now && level_q > CNT_MIN) |=> level_q == $past(level_q) - 1'b1);

endmodule

// File: rtl/neuron_fire_cmp.sv
module neuron_fire_cmp #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] syn_level,
  input  logic [CNT_W-1:0] wgt_level,
  output logic             fire_now,
  output logic             fire_q
);
  assign fire_now = (syn_level == wgt_level);

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= fire_now;
  end

  // R10
  fire_single_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);

  // R6
  fire_late_chk: assert property (@(posedge clk) disable iff (rst)
    fire_now |=> fire_q);

endmodule

// File: rtl/adaptive_neuron.sv
module adaptive_neuron #(
  parameter int CNT_W = 5,
  parameter int INIT_THRESH = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             excite,
  input  logic             inhibit,
  input  logic             leak,
  input  logic             recover,
  output logic             fire,
  output logic [CNT_W-1:0] syn_count,
  output logic [CNT_W-1:0] threshold
);
  logic             fire_now;
  logic [CNT_W-1:0] syn_lvl;
  logic [CNT_W-1:0] wgt_lvl;

  neuron_syn_acc #(.CNT_W(CNT_W)) u_syn (
    .clk(clk), .rst(rst), .fire_now(fire_now),
    .excite(excite), .inhibit(inhibit), .leak(leak), .level(syn_lvl)
  );

  neuron_wgt_acc #(.CNT_W(CNT_W), .INIT_THRESH(INIT_THRESH)) u_wgt (
    .clk(clk), .rst(rst), .fire_now(fire_now),
    .recover(recover), .level(wgt_lvl)
  );

  neuron_fire_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .syn_level(syn_lvl), .wgt_level(wgt_lvl),
    .fire_now(fire_now), .fire_q(fire)
  );

  assign syn_count = syn_lvl;
  assign threshold = wgt_lvl;

  // R6
  fire_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> syn_count == '0);

  // R7
  fire_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && $past(threshold) > 1) |-> threshold == $past(threshold) - 1'b1);

endmodule

// File: tb/test_adaptive_neuron.sv
module test_adaptive_neuron;
  localparam int W = 5;
  localparam int MAXV = 31;
  localparam int INIT = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic excite = 1'b0, inhibit = 1'b0, leak = 1'b0, recover = 1'b0;
  logic fire;
  logic [W-1:0] syn_count, threshold;

  int checks = 0;
  int failures = 0;
  int m_syn, m_wgt, m_fire, prev_fire;
  bit done = 0;

  always #10 clk = ~clk;

  adaptive_neuron #(.CNT_W(W), .INIT_THRESH(INIT)) i_adaptive_neuron (
    .clk(clk), .rst(rst), .excite(excite), .inhibit(inhibit), .leak(leak),
    .recover(recover), .fire(fire), .syn_count(syn_count), .threshold(threshold)
  );

  function automatic int next_syn(int s, int w, bit e, bit i, bit l);
    if (s == w) return 0;
    if (e && !i) return (s < MAXV) ? s + 1 : s;
    if (i && !e) return (s > 0) ? s - 1 : s;
    if (!e && !i && l) return (s > 0) ? s - 1 : s;
    return s;
  endfunction

  function automatic int next_wgt(int s, int w, bit r);
    if (s == w) return (w > 1) ? w - 1 : 1;
    if (r) return (w < MAXV) ? w + 1 : w;
    return w;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit e, bit i, bit l, bit r, string tag);
    int ns, nw;
    excite = e; inhibit = i; leak = l; recover = r;
    ns = next_syn(m_syn, m_wgt, e, i, l);
    nw = next_wgt(m_syn, m_wgt, r);
    prev_fire = m_fire;
    m_fire = (m_syn == m_wgt) ? 1 : 0;
    m_syn = ns; m_wgt = nw;
    @(negedge clk);
    check(tag, "syn_count", int'(syn_count), m_syn);
    check(tag, "threshold", int'(threshold), m_wgt);
    check(tag, "fire", int'(fire), m_fire);
    if (prev_fire == 1 && fire === 1'b1) begin
      checks++; failures++;
      $display("FAIL R10 fire high twice actual=1 expected=0");
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "syn_count", int'(syn_count), 0);
    check("R1", "threshold", int'(threshold), INIT);
    check("R1", "fire", int'(fire), 0);
    rst = 1'b0;
    m_syn = 0; m_wgt = INIT; m_fire = 0; prev_fire = 0;

    // R4 lower saturation
    step(0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, "R4");
    // R2 up and down
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R2");
    // R3 cancel, leak ignored
    step(1, 1, 1, 0, "R3");
    step(1, 1, 0, 0, "R3");
    // R5 leak
    step(0, 0, 1, 0, "R5");
    step(0, 0, 1, 0, "R5");
    // R6 and R9: climb to threshold, then inputs and recover during fire
    while (m_syn != m_wgt) step(1, 0, 0, 0, "R6");
    step(1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, "R10");
    // R7: walk threshold to floor, fire several times at floor
    while (m_wgt > 1 || m_fire == 0) step(1, 0, 0, 0, "R7");
    for (int k = 0; k < 6; k++) step(1, 0, 0, 1, "R7");
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0, "R7");
    // R8 recovery to ceiling
    step(0, 1, 0, 0, "R8");
    for (int k = 0; k < 40; k++) step(0, 0, 0, 1, "R8");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit e, i, l, r;
      e = ($urandom % 100) < 55;
      i = ($urandom % 100) < 20;
      l = ($urandom % 100) < 15;
      r = ($urandom % 100) < 8;
      step(e, i, l, r, "R6");
    end
    // R1 reset mid-run
    rst = 1'b1; excite = 1'b1;
    @(negedge clk);
    check("R1", "syn_count", int'(syn_count), 0);
    check("R1", "threshold", int'(threshold), INIT);
    check("R1", "fire", int'(fire), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule